// File: doc/BRIEF.md
# One-Bit LRU Victim Selector for a Translation Buffer

This block picks the slot that an automatic fill overwrites in a fully associative translation buffer. The buffer storage sits outside the block and supplies three per-entry status vectors: valid, locked and used. A fill request carries the new tag, taken from the tag-access register, and the new translation word, which is the data value being written. The selector captures both, chooses a slot, and then issues one write strobe with the slot index and the captured tag and data.

Empty slots come first: the lowest-numbered invalid slot wins. If every slot is valid, the lowest slot that is both unlocked and not recently used wins. If no such slot exists, the block pulses a bulk-clear of every used bit and runs the search a second time. Once the used bits are clear, any unlocked slot qualifies. If every slot is locked, the fill is dropped and a failure flag pulses. Each stage of the search uses a combinational priority encoder, so a fill finishes in at most three clock edges after it is accepted.

Top module: `lru1_victim_sel`

## Requirements
- R1: After synchronous reset, `wr_en`, `used_clr` and `fill_drop` are 0 and `wr_idx` is 0.
- R2: If any entry has its valid bit at 0, the fill writes the lowest-index such entry, whatever the lock and used bits are.
- R3: If all entries are valid, the fill writes the lowest-index entry whose lock bit and used bit are both 0.
- R4: If all entries are valid and none is both unlocked and unused, `used_clr` pulses for one cycle. The fill then writes the lowest-index unlocked entry.
- R5: If all entries are valid and all are locked, there is no write, and `fill_drop` pulses for exactly one cycle, one cycle after the `used_clr` pulse.
- R6: A successful fill raises `wr_en` for exactly one cycle, with `wr_idx`, `wr_tag` and `wr_data` valid at the same time. `wr_tag` and `wr_data` equal the values present with the accepted request.
- R7: Take the clock edge on which the request is accepted as edge 0. For an invalid or free slot the result appears after edge 1. When a clear and retry is needed, `used_clr` appears after edge 1 and the write or drop appears after edge 2.
- R8: `fill_req` is ignored while a fill is in progress. No second write occurs, and the captured tag and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_req | input | 1 | Fill request, accepted when idle |
| fill_tag | input | TAG_W | Tag for the new entry |
| fill_data | input | DATA_W | Translation word for the new entry |
| valid_bits | input | N_ENT | Per-entry valid status |
| locked_bits | input | N_ENT | Per-entry lock status |
| used_bits | input | N_ENT | Per-entry recently-used status |
| wr_en | output | 1 | One-cycle write strobe into the buffer |
| wr_idx | output | IDX_W | Slot to write |
| wr_tag | output | TAG_W | Tag to write |
| wr_data | output | DATA_W | Translation word to write |
| used_clr | output | 1 | One-cycle request to clear every used bit |
| fill_drop | output | 1 | One-cycle flag: fill dropped, all slots locked |

## Verification
The in-RTL assertions check the following on every cycle:
- At most one of write, clear and drop is active at once.
- Write and drop pulses last a single cycle.
- A clear is always followed by a write or a drop.
- The captured request stays stable while a fill is in progress.

The bench scenarios cover what the assertions cannot:
- Which slot wins under each status pattern: invalid ahead of free, lowest index first, and the top index.
- The exact cycle on which each result appears.
- That the written tag and data belong to the first request, not to a later one presented while busy.

// File: rtl/lru1_pkg.sv
package lru1_pkg;

    localparam int unsigned DEF_ENTRIES = 64;
    localparam int unsigned DEF_WORD_W  = 64;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PICK  = 2'd1,
        ST_RETRY = 2'd2
    } sel_state_e;

    // Candidate classes, in order of decreasing preference
    localparam int unsigned CLS_EMPTY    = 0;
    localparam int unsigned CLS_FREE     = 1;
    localparam int unsigned CLS_UNLOCKED = 2;
    localparam int unsigned CLS_COUNT    = 3;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lru1_prienc.sv
module lru1_prienc #(
    parameter int unsigned N  = 64,
    parameter int unsigned IW = 6
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Lowest set bit wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lru1_cand.sv
module lru1_cand
    import lru1_pkg::*;
#(
    parameter int unsigned N  = 64,
    parameter int unsigned IW = 6
) (
    input  logic [N-1:0]            valid_bits,
    input  logic [N-1:0]            locked_bits,
    input  logic [N-1:0]            used_bits,
    output logic [CLS_COUNT-1:0]    cls_any,
    output logic [CLS_COUNT-1:0][IW-1:0] cls_idx
);
    logic [CLS_COUNT-1:0][N-1:0] cls_mask;

    always_comb begin
        cls_mask[CLS_EMPTY]    = ~valid_bits;
        cls_mask[CLS_FREE]     = ~locked_bits & ~used_bits;
        // After the bulk clear every unlocked slot counts as unused
        cls_mask[CLS_UNLOCKED] = ~locked_bits;
    end

    for (genvar g = 0; g < CLS_COUNT; g++) begin : g_enc
        lru1_prienc #(.N(N), .IW(IW)) enc_i (
            .req (cls_mask[g]),
            .any (cls_any[g]),
            .idx (cls_idx[g])
        );
    end
endmodule

// File: rtl/lru1_victim_sel.sv
module lru1_victim_sel
    import lru1_pkg::*;
#(
    parameter int unsigned N_ENT  = DEF_ENTRIES,
    parameter int unsigned TAG_W  = DEF_WORD_W,
    parameter int unsigned DATA_W = DEF_WORD_W,
    parameter int unsigned IDX_W  = idx_width(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_req,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [N_ENT-1:0]  valid_bits,
    input  logic [N_ENT-1:0]  locked_bits,
    input  logic [N_ENT-1:0]  used_bits,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output logic              used_clr,
    output logic              fill_drop
);
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } fill_t;

    sel_state_e                       state;
    fill_t                            cap;
    logic [CLS_COUNT-1:0]             cls_any;
    logic [CLS_COUNT-1:0][IDX_W-1:0]  cls_idx;

    lru1_cand #(.N(N_ENT), .IW(IDX_W)) cand_i (
        .valid_bits  (valid_bits),
        .locked_bits (locked_bits),
        .used_bits   (used_bits),
        .cls_any     (cls_any),
        .cls_idx     (cls_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cap       <= '0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            used_clr  <= 1'b0;
            fill_drop <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            used_clr  <= 1'b0;
            fill_drop <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (fill_req) begin
                        cap   <= '{tag: fill_tag, data: fill_data};
                        state <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (cls_any[CLS_EMPTY]) begin
                        wr_en  <= 1'b1;
                        wr_idx <= cls_idx[CLS_EMPTY];
                        state  <= ST_IDLE;
                    end else if (cls_any[CLS_FREE]) begin
                        wr_en  <= 1'b1;
                        wr_idx <= cls_idx[CLS_FREE];
                        state  <= ST_IDLE;
                    end else begin
                        used_clr <= 1'b1;
                        state    <= ST_RETRY;
                    end
                end
                ST_RETRY: begin
                    if (cls_any[CLS_UNLOCKED]) begin
                        wr_en  <= 1'b1;
                        wr_idx <= cls_idx[CLS_UNLOCKED];
                    end else begin
                        fill_drop <= 1'b1;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign wr_tag  = cap.tag;
    assign wr_data = cap.data;

    p_one_action_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, used_clr, fill_drop}));

    p_wr_single_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    p_clr_resolves_r4: assert property (@(posedge clk) disable iff (rst)
        used_clr |=> (wr_en || fill_drop));

    p_drop_single_r5: assert property (@(posedge clk) disable iff (rst)
        fill_drop |=> !fill_drop);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(cap));

endmodule

// File: tb/lru1_victim_sel_tb_top.sv
`timescale 1ns/1ps
module lru1_victim_sel_tb_top;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          fill_req;
    logic [63:0]   fill_tag, fill_data;
    logic [N-1:0]  valid_bits, locked_bits, used_bits;
    logic          wr_en, used_clr, fill_drop;
    logic [5:0]    wr_idx;
    logic [63:0]   wr_tag, wr_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lru1_victim_sel dut_i (
        .clk(clk), .rst(rst), .fill_req(fill_req), .fill_tag(fill_tag),
        .fill_data(fill_data), .valid_bits(valid_bits), .locked_bits(locked_bits),
        .used_bits(used_bits), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_data(wr_data), .used_clr(used_clr), .fill_drop(fill_drop)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Result record of one fill
    int    r_wr_cnt, r_wr_at, r_idx, r_clr_cnt, r_clr_at, r_drop_cnt, r_drop_at;
    logic [63:0] r_tag, r_data;

    // Issue a request at a negedge and watch six edges
    task automatic run_fill(input logic [63:0] tag, input logic [63:0] data, input int hold);
        r_wr_cnt = 0; r_wr_at = -1; r_idx = -1; r_clr_cnt = 0; r_clr_at = -1;
        r_drop_cnt = 0; r_drop_at = -1; r_tag = '0; r_data = '0;
        @(negedge clk);
        fill_req = 1'b1; fill_tag = tag; fill_data = data;
        for (int s = 0; s < 6; s++) begin
            @(negedge clk);
            if (wr_en) begin
                r_wr_cnt++; r_wr_at = s; r_idx = int'(wr_idx);
                r_tag = wr_tag; r_data = wr_data;
            end
            if (used_clr) begin
                r_clr_cnt++; r_clr_at = s; used_bits = '0;
            end
            if (fill_drop) begin
                r_drop_cnt++; r_drop_at = s;
            end
            if (s + 1 == hold) fill_req = 1'b0;
            else begin
                fill_tag = ~tag; fill_data = ~data;
            end
        end
        fill_req = 1'b0;
    endtask

    task automatic t_reset;
        chk(wr_en == 1'b0, "R1", "wr_en after reset", 64'(wr_en), 0);
        chk(used_clr == 1'b0, "R1", "used_clr after reset", 64'(used_clr), 0);
        chk(fill_drop == 1'b0, "R1", "fill_drop after reset", 64'(fill_drop), 0);
        chk(wr_idx == 6'd0, "R1", "wr_idx after reset", 64'(wr_idx), 0);
    endtask

    task automatic t_empty_low;
        valid_bits = '1; valid_bits[5] = 1'b0; valid_bits[40] = 1'b0;
        locked_bits = '0; locked_bits[5] = 1'b1; used_bits = '1;
        run_fill(64'hA5A5_0000_1111_2222, 64'h8000_0000_0000_0042, 1);
        chk(r_idx == 5, "R2", "lowest invalid index", 64'(r_idx), 5);
        chk(r_wr_at == 1, "R7", "direct write cycle", 64'(r_wr_at), 1);
        chk(r_wr_cnt == 1, "R6", "write pulse count", 64'(r_wr_cnt), 1);
        chk(r_tag == 64'hA5A5_0000_1111_2222, "R6", "wr_tag", r_tag, 64'hA5A5_0000_1111_2222);
        chk(r_data == 64'h8000_0000_0000_0042, "R6", "wr_data", r_data, 64'h8000_0000_0000_0042);
        chk(r_clr_cnt == 0, "R2", "no used clear", 64'(r_clr_cnt), 0);
    endtask

    task automatic t_empty_top;
        valid_bits = '1; valid_bits[63] = 1'b0; locked_bits = '0; used_bits = '0;
        run_fill(64'h1, 64'h2, 1);
        chk(r_idx == 63, "R2", "top index invalid", 64'(r_idx), 63);
    endtask

    task automatic t_empty_beats_free;
        valid_bits = '1; valid_bits[50] = 1'b0; locked_bits = '0; used_bits = '1; used_bits[3] = 1'b0;
        run_fill(64'h3, 64'h4, 1);
        chk(r_idx == 50, "R2", "invalid preferred over free", 64'(r_idx), 50);
    endtask

    task automatic t_free;
        valid_bits = '1; locked_bits = 64'h0000_0000_0000_03FF;
        used_bits = 64'h0000_0000_000F_FC00;
        run_fill(64'hCAFE, 64'hBEEF, 1);
        chk(r_idx == 20, "R3", "lowest unlocked unused", 64'(r_idx), 20);
        chk(r_wr_at == 1, "R7", "free write cycle", 64'(r_wr_at), 1);
        chk(r_clr_cnt == 0, "R3", "no used clear", 64'(r_clr_cnt), 0);
    endtask

    task automatic t_clear_retry;
        valid_bits = '1; locked_bits = 64'hF; used_bits = '1;
        run_fill(64'h7777, 64'h8888, 1);
        chk(r_clr_cnt == 1, "R4", "used_clr pulse count", 64'(r_clr_cnt), 1);
        chk(r_clr_at == 1, "R7", "used_clr cycle", 64'(r_clr_at), 1);
        chk(r_wr_at == 2, "R7", "retry write cycle", 64'(r_wr_at), 2);
        chk(r_idx == 4, "R4", "retry index", 64'(r_idx), 4);
        chk(r_wr_cnt == 1, "R6", "retry write count", 64'(r_wr_cnt), 1);
    endtask

    task automatic t_all_locked;
        valid_bits = '1; locked_bits = '1; used_bits = '0;
        run_fill(64'h9, 64'hA, 1);
        chk(r_wr_cnt == 0, "R5", "no write when all locked", 64'(r_wr_cnt), 0);
        chk(r_drop_cnt == 1, "R5", "drop pulse count", 64'(r_drop_cnt), 1);
        chk(r_drop_at == 2, "R5", "drop cycle", 64'(r_drop_at), 2);
        chk(r_clr_at == 1, "R5", "clear before drop", 64'(r_clr_at), 1);
    endtask

    task automatic t_busy;
        valid_bits = '1; locked_bits = 64'h3; used_bits = '1;
        run_fill(64'h1234_5678, 64'h9ABC_DEF0, 2);
        chk(r_wr_cnt == 1, "R8", "single write with held request", 64'(r_wr_cnt), 1);
        chk(r_idx == 2, "R8", "index of first fill", 64'(r_idx), 2);
        chk(r_tag == 64'h1234_5678, "R8", "tag of first fill", r_tag, 64'h1234_5678);
        chk(r_data == 64'h9ABC_DEF0, "R8", "data of first fill", r_data, 64'h9ABC_DEF0);
    endtask

    initial begin
        rst = 1'b1; fill_req = 1'b0; fill_tag = '0; fill_data = '0;
        valid_bits = '0; locked_bits = '0; used_bits = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_empty_low();
        t_empty_top();
        t_empty_beats_free();
        t_free();
        t_clear_retry();
        t_all_locked();
        t_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule